// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks line reservations for a cache controller that supports load-linked (LL) and store-conditional (SC) pairs and locked read-modify-write sequences. The controller reports each completed access on a single completion port. The report carries the access kind, the line address, the requester identifier, and whether the line is present in the local cache. The monitor updates its reservation slots from each report. One cycle later it returns a response strobe with a success flag, which is 0 only for a failed store-conditional.

A separate invalidation port reports that coherence permission for a line was lost. It also tells the block whether a store-conditional to that line is pending, and in that case the reservation on the line is dropped. A second small table records lines that have an open locked read-modify-write. The controller presents a line on a query input, and the block answers combinationally whether requests to that line must be held back.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no line is reserved, no line is blocked, and `rspValid` is 0. A store-conditional issued before any load-linked fails.
- R2: Each completion with `cplValid`=1 produces exactly one cycle of `rspValid`=1 in the next cycle. Load (kind 0), instruction fetch (1), store (2), load-linked (3), locked read (5), locked write (6) and the unused code 7 always report `rspSuccess`=1.
- R3: A load-linked (kind 3) reserves its line for its `cplReqId`. A later store-conditional (kind 4) to that line from the same requester reports `rspSuccess`=1.
- R4: A store-conditional reports `rspSuccess`=0 when its line is not reserved, or when the line is reserved by a different requester.
- R5: Every store-conditional removes the reservation on its line, whatever the owner and whatever the outcome. A second store-conditional to the same line therefore fails.
- R6: A store, locked read or locked write removes a reservation only when `cplPresent`=1 and the reservation's requester equals `cplReqId`. A write by another requester, or a write with `cplPresent`=0, leaves the reservation in place.
- R7: `invValid`=1 with `invScPending`=1 removes any reservation on `invLine`. With `invScPending`=0 the invalidation has no effect.
- R8: When a pending-SC invalidation names the same line as a completion in the same cycle, the invalidation wins. A load-linked still reports 1 but reserves nothing. A store-conditional reports 0. An invalidation of a different line does not interfere.
- R9: At most `NUM_SLOTS` lines are reserved. A load-linked to a new line with all slots taken evicts the reservation that was made earliest. Freed slots are reused before any eviction.
- R10: A completed locked read (kind 5) makes `qryBlocked`=1 for that line from the next cycle. A completed locked write (kind 6) to the line clears it from the next cycle. Other lines are unaffected.
- R11: Loads and instruction fetches never change any reservation.
- R12: A load-linked to a line that is already reserved moves the reservation to the new requester in the same slot. It does not occupy a second slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cplValid | input | 1 | A completed access is reported this cycle |
| cplKind | input | 3 | Access kind: 0 load, 1 fetch, 2 store, 3 LL, 4 SC, 5 locked read, 6 locked write, 7 unused |
| cplLine | input | LINE_W | Line address of the completion |
| cplReqId | input | ID_W | Requester identifier of the completion |
| cplPresent | input | 1 | Line is present in the local cache |
| invValid | input | 1 | Coherence permission lost on `invLine` |
| invLine | input | LINE_W | Line address of the invalidation |
| invScPending | input | 1 | A store-conditional to `invLine` is pending |
| qryLine | input | LINE_W | Line whose blocked status is asked |
| qryBlocked | output | 1 | `qryLine` has an open locked read-modify-write |
| rspValid | output | 1 | Response for the previous cycle's completion |
| rspSuccess | output | 1 | 1 on success; 0 only for a failed store-conditional |

## Verification
A pending-SC invalidation can land in the same cycle as a completion to the same line. The bench provokes this with a load-linked and, separately, with a store-conditional. A control case pairs an invalidation of a neighbouring line with a succeeding store-conditional. The outcome is judged through the response of the colliding access and through a follow-up store-conditional that shows whether a reservation survived. Eviction order is exercised with and without a slot freed beforehand.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [2:0] {
    ACC_LOAD   = 3'd0,
    ACC_IFETCH = 3'd1,
    ACC_STORE  = 3'd2,
    ACC_LL     = 3'd3,
    ACC_SC     = 3'd4,
    ACC_LKRD   = 3'd5,
    ACC_LKWR   = 3'd6,
    ACC_RSVD   = 3'd7
  } accKind_e;

  // Strobes from control to datapath, one completion at a time.
  typedef struct packed {
    logic llSet;   // reserve line for requester
    logic scChk;   // store-conditional: test and drop line
    logic wrClr;   // write-class: drop own reservation if present
    logic blkSet;  // open locked read-modify-write on line
    logic blkClr;  // close locked read-modify-write on line
  } resvStrobe_t;

endpackage

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cplValid,
  input  logic [2:0]  cplKind,
  input  logic        scOk,
  output resvStrobe_t stb,
  output logic        rspValid,
  output logic        rspSuccess
);

  accKind_e kind;
  logic     isSc;

  always_comb begin
    kind       = accKind_e'(cplKind);
    isSc       = cplValid && (kind == ACC_SC);
    stb        = '0;
    stb.llSet  = cplValid && (kind == ACC_LL);
    stb.scChk  = isSc;
    stb.wrClr  = cplValid && ((kind == ACC_STORE) || (kind == ACC_LKRD) || (kind == ACC_LKWR));
    stb.blkSet = cplValid && (kind == ACC_LKRD);
    stb.blkClr = cplValid && (kind == ACC_LKWR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspSuccess <= 1'b0;
    end else begin
      rspValid   <= cplValid;
      rspSuccess <= isSc ? scOk : 1'b1;
    end
  end

endmodule

// File: rtl/llsc_resv_dp.sv
module llsc_resv_dp
  import llsc_pkg::*;
#(
  parameter int LINE_W    = 16,
  parameter int ID_W      = 4,
  parameter int NUM_SLOTS = 4,
  parameter int NUM_BLK   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  resvStrobe_t       stb,
  input  logic [LINE_W-1:0] cplLine,
  input  logic [ID_W-1:0]   cplReqId,
  input  logic              cplPresent,
  input  logic              invValid,
  input  logic [LINE_W-1:0] invLine,
  input  logic              invScPending,
  input  logic [LINE_W-1:0] qryLine,
  output logic              scOk,
  output logic              qryBlocked
);

  localparam int IDX_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int RANK_W = IDX_W;
  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(NUM_SLOTS - 1);

  // reservation slots; rank 0 is the newest, ranks stay compact
  logic [NUM_SLOTS-1:0] slotV;
  logic [LINE_W-1:0]    slotLine [NUM_SLOTS];
  logic [ID_W-1:0]      slotId   [NUM_SLOTS];
  logic [RANK_W-1:0]    slotRank [NUM_SLOTS];

  logic [NUM_SLOTS-1:0] lineHit, ownHit, invHit, clr, freed;
  logic [RANK_W-1:0]    nextRank [NUM_SLOTS];
  logic                 vetoHit, doLl, doIns, freeFound;
  logic [IDX_W-1:0]     freeIdx, victimIdx, insIdx;

  assign vetoHit = invValid && invScPending && (invLine == cplLine);

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      lineHit[i] = slotV[i] && (slotLine[i] == cplLine);
      ownHit[i]  = lineHit[i] && (slotId[i] == cplReqId);
      invHit[i]  = invValid && invScPending && slotV[i] && (slotLine[i] == invLine);
      clr[i]     = invHit[i] || (stb.scChk && lineHit[i]) ||
                   (stb.wrClr && cplPresent && ownHit[i]);
    end
  end

  assign scOk  = (|ownHit) && !vetoHit;
  assign doLl  = stb.llSet && !vetoHit;
  assign doIns = doLl && !(|lineHit);

  always_comb begin
    freeFound = 1'b0;
    freeIdx   = '0;
    victimIdx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!slotV[i] && !freeFound) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
      if (slotRank[i] == OLDEST) victimIdx = IDX_W'(i);
    end
    insIdx = freeFound ? freeIdx : victimIdx;
  end

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++)
      freed[i] = clr[i] || (doIns && !freeFound && (insIdx == IDX_W'(i)));
  end

  // survivors close the gaps left by freed slots, then age by one on insert
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      int dec;
      dec = 0;
      for (int j = 0; j < NUM_SLOTS; j++)
        if (freed[j] && slotV[j] && (slotRank[j] < slotRank[i])) dec++;
      nextRank[i] = RANK_W'(int'(slotRank[i]) - dec + (doIns ? 1 : 0));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotV <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        slotLine[i] <= '0;
        slotId[i]   <= '0;
        slotRank[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (doIns && (insIdx == IDX_W'(i))) begin
          slotV[i]    <= 1'b1;
          slotLine[i] <= cplLine;
          slotId[i]   <= cplReqId;
          slotRank[i] <= '0;
        end else if (freed[i]) begin
          slotV[i]    <= 1'b0;
          slotRank[i] <= '0;
        end else if (slotV[i]) begin
          slotRank[i] <= nextRank[i];
          if (doLl && lineHit[i]) slotId[i] <= cplReqId;
        end
      end
    end
  end

  // blocked-line table for locked read-modify-write
  logic [NUM_BLK-1:0] blkV, blkHit, qryHit, blkIns;
  logic [LINE_W-1:0]  blkLine [NUM_BLK];

  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int k = 0; k < NUM_BLK; k++) begin
      blkHit[k] = blkV[k] && (blkLine[k] == cplLine);
      qryHit[k] = blkV[k] && (blkLine[k] == qryLine);
    end
    for (int k = 0; k < NUM_BLK; k++) begin
      blkIns[k] = stb.blkSet && !(|blkHit) && !blkV[k] && !taken;
      if (blkIns[k]) taken = 1'b1;
    end
  end

  assign qryBlocked = |qryHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkV <= '0;
      for (int k = 0; k < NUM_BLK; k++) blkLine[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_BLK; k++) begin
        if (blkIns[k]) begin
          blkV[k]    <= 1'b1;
          blkLine[k] <= cplLine;
        end else if (stb.blkClr && blkHit[k]) begin
          blkV[k] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int LINE_W    = 16,
  parameter int ID_W      = 4,
  parameter int NUM_SLOTS = 4,
  parameter int NUM_BLK   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cplValid,
  input  logic [2:0]        cplKind,
  input  logic [LINE_W-1:0] cplLine,
  input  logic [ID_W-1:0]   cplReqId,
  input  logic              cplPresent,
  input  logic              invValid,
  input  logic [LINE_W-1:0] invLine,
  input  logic              invScPending,
  input  logic [LINE_W-1:0] qryLine,
  output logic              qryBlocked,
  output logic              rspValid,
  output logic              rspSuccess
);

  resvStrobe_t stb;
  logic        scOk;

  llsc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cplValid   (cplValid),
    .cplKind    (cplKind),
    .scOk       (scOk),
    .stb        (stb),
    .rspValid   (rspValid),
    .rspSuccess (rspSuccess)
  );

  llsc_resv_dp #(
    .LINE_W    (LINE_W),
    .ID_W      (ID_W),
    .NUM_SLOTS (NUM_SLOTS),
    .NUM_BLK   (NUM_BLK)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .cplLine      (cplLine),
    .cplReqId     (cplReqId),
    .cplPresent   (cplPresent),
    .invValid     (invValid),
    .invLine      (invLine),
    .invScPending (invScPending),
    .qryLine      (qryLine),
    .scOk         (scOk),
    .qryBlocked   (qryBlocked)
  );

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int LINE_W = 16,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cplValid,
  input logic [2:0]        cplKind,
  input logic [LINE_W-1:0] cplLine,
  input logic [ID_W-1:0]   cplReqId,
  input logic              invValid,
  input logic [LINE_W-1:0] invLine,
  input logic              invScPending,
  input logic [LINE_W-1:0] qryLine,
  input logic              qryBlocked,
  input logic              rspValid,
  input logic              rspSuccess
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !rspValid);

  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplValid |=> rspValid);

  // R2
  rsp_no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cplValid |=> !rspValid);

  // R4
  fail_only_sc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && cplKind != 3'd4) |=> rspSuccess);

  // R8
  inv_veto_sc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && cplKind == 3'd4 && invValid && invScPending && invLine == cplLine)
      |=> (rspValid && !rspSuccess));

  // R10
  unblock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && cplKind == 3'd6 && qryLine == cplLine) |=>
      ((qryLine == $past(cplLine)) -> !qryBlocked));

endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W), .ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cplValid     (cplValid),
  .cplKind      (cplKind),
  .cplLine      (cplLine),
  .cplReqId     (cplReqId),
  .invValid     (invValid),
  .invLine      (invLine),
  .invScPending (invScPending),
  .qryLine      (qryLine),
  .qryBlocked   (qryBlocked),
  .rspValid     (rspValid),
  .rspSuccess   (rspSuccess)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;

  localparam int LINE_W = 16;
  localparam int ID_W   = 4;

  localparam logic [2:0] K_LD = 3'd0, K_IF = 3'd1, K_ST = 3'd2, K_LL = 3'd3,
                         K_SC = 3'd4, K_LR = 3'd5, K_LW = 3'd6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cplValid = 1'b0;
  logic [2:0]        cplKind = '0;
  logic [LINE_W-1:0] cplLine = '0;
  logic [ID_W-1:0]   cplReqId = '0;
  logic              cplPresent = 1'b0;
  logic              invValid = 1'b0;
  logic [LINE_W-1:0] invLine = '0;
  logic              invScPending = 1'b0;
  logic [LINE_W-1:0] qryLine = '0;
  logic              qryBlocked, rspValid, rspSuccess;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic  succ;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;

  llsc_monitor u_llsc_monitor (
    .clk(clk), .rstN(rstN), .cplValid(cplValid), .cplKind(cplKind),
    .cplLine(cplLine), .cplReqId(cplReqId), .cplPresent(cplPresent),
    .invValid(invValid), .invLine(invLine), .invScPending(invScPending),
    .qryLine(qryLine), .qryBlocked(qryBlocked), .rspValid(rspValid),
    .rspSuccess(rspSuccess)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // driver: one completion, optional same-cycle invalidation
  task automatic op(input logic [2:0] k, input int line, input int id, input logic pres,
                    input logic iv, input int iline, input logic ipend,
                    input logic exp, input string tag);
    expItem_t it;
    @(negedge clk);
    cplValid = 1'b1; cplKind = k; cplLine = LINE_W'(line); cplReqId = ID_W'(id);
    cplPresent = pres; invValid = iv; invLine = LINE_W'(iline); invScPending = ipend;
    it.succ = exp; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic acc(input logic [2:0] k, input int line, input int id,
                     input logic exp, input string tag);
    op(k, line, id, 1'b1, 1'b0, 0, 1'b0, exp, tag);
  endtask

  task automatic idle(input logic iv, input int iline, input logic ipend);
    @(negedge clk);
    cplValid = 1'b0; invValid = iv; invLine = LINE_W'(iline); invScPending = ipend;
  endtask

  task automatic chkBlk(input int line, input logic exp, input string tag);
    @(negedge clk);
    cplValid = 1'b0; invValid = 1'b0; qryLine = LINE_W'(line);
    #1 check(tag, qryBlocked, exp);
  endtask

  // monitor: pop expected response when the design produces one
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rspValid) begin
        if (expQ.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL R2 unexpected response: actual 1 expected 0");
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.tag, rspSuccess, it.succ);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 rspValid in reset", rspValid, 1'b0);
    rstN = 1'b1;
    chkBlk(16'h5, 1'b0, "R1 no blocked line after reset");
    acc(K_SC, 16'h10, 1, 1'b0, "R1 SC with no reservation");
    // R2 R3 R5
    acc(K_LL, 16'h10, 1, 1'b1, "R2 LL success");
    acc(K_SC, 16'h10, 1, 1'b1, "R3 SC same requester");
    acc(K_SC, 16'h10, 1, 1'b0, "R5 second SC fails");
    // R4 R5
    acc(K_LL, 16'h20, 1, 1'b1, "R2 LL");
    acc(K_SC, 16'h20, 2, 1'b0, "R4 SC other requester");
    acc(K_SC, 16'h20, 1, 1'b0, "R5 failed SC cleared lock");
    // R6 R11
    acc(K_LL, 16'h30, 1, 1'b1, "R2 LL");
    acc(K_LD, 16'h30, 2, 1'b1, "R11 load success");
    acc(K_IF, 16'h30, 1, 1'b1, "R11 fetch success");
    acc(K_ST, 16'h30, 2, 1'b1, "R6 store other id success");
    op(K_ST, 16'h30, 1, 1'b0, 1'b0, 0, 1'b0, 1'b1, "R6 store not present");
    acc(3'd7, 16'h30, 1, 1'b1, "R2 unused code success");
    acc(K_SC, 16'h30, 1, 1'b1, "R6 R11 reservation survived");
    acc(K_LL, 16'h40, 3, 1'b1, "R2 LL");
    acc(K_ST, 16'h40, 3, 1'b1, "R2 store success");
    acc(K_SC, 16'h40, 3, 1'b0, "R6 own store cleared lock");
    // R7
    acc(K_LL, 16'h50, 1, 1'b1, "R2 LL");
    idle(1'b1, 16'h50, 1'b0);
    acc(K_SC, 16'h50, 1, 1'b1, "R7 inv without pending SC ignored");
    acc(K_LL, 16'h50, 1, 1'b1, "R2 LL");
    idle(1'b1, 16'h50, 1'b1);
    acc(K_SC, 16'h50, 1, 1'b0, "R7 inv with pending SC clears");
    // R8
    op(K_LL, 16'h60, 1, 1'b1, 1'b1, 16'h60, 1'b1, 1'b1, "R8 LL with inv still succeeds");
    acc(K_SC, 16'h60, 1, 1'b0, "R8 vetoed LL reserved nothing");
    acc(K_LL, 16'h61, 1, 1'b1, "R2 LL");
    op(K_SC, 16'h61, 1, 1'b1, 1'b1, 16'h61, 1'b1, 1'b0, "R8 SC with same-line inv fails");
    acc(K_SC, 16'h61, 1, 1'b0, "R8 lock gone after collision");
    acc(K_LL, 16'h62, 1, 1'b1, "R2 LL");
    op(K_SC, 16'h62, 1, 1'b1, 1'b1, 16'h63, 1'b1, 1'b1, "R8 other-line inv no veto");
    // R9 eviction with full table
    for (int i = 0; i < 5; i++) acc(K_LL, 16'h70 + i, 1, 1'b1, "R2 LL");
    acc(K_SC, 16'h70, 1, 1'b0, "R9 oldest evicted");
    for (int i = 1; i < 5; i++) acc(K_SC, 16'h70 + i, 1, 1'b1, "R9 younger kept");
    // R9 free slot reused, then eviction picks oldest survivor
    for (int i = 0; i < 4; i++) acc(K_LL, 16'h80 + i, 1, 1'b1, "R2 LL");
    acc(K_SC, 16'h80, 1, 1'b1, "R3 SC frees slot");
    acc(K_LL, 16'h84, 1, 1'b1, "R2 LL");
    acc(K_LL, 16'h85, 1, 1'b1, "R2 LL");
    acc(K_SC, 16'h81, 1, 1'b0, "R9 oldest survivor evicted");
    for (int i = 2; i < 6; i++) acc(K_SC, 16'h80 + i, 1, 1'b1, "R9 others kept");
    // R12
    acc(K_LL, 16'h91, 1, 1'b1, "R2 LL");
    for (int i = 2; i < 5; i++) acc(K_LL, 16'h90 + i, 1, 1'b1, "R2 LL");
    acc(K_LL, 16'h91, 2, 1'b1, "R2 LL retag");
    acc(K_LL, 16'h91, 3, 1'b1, "R2 LL retag");
    acc(K_SC, 16'h92, 1, 1'b1, "R12 retag took no slot");
    acc(K_SC, 16'h91, 1, 1'b0, "R12 old owner lost line");
    acc(K_LL, 16'h91, 3, 1'b1, "R2 LL");
    acc(K_SC, 16'h91, 3, 1'b1, "R12 new owner holds line");
    acc(K_SC, 16'h93, 1, 1'b1, "R12 slot kept");
    acc(K_SC, 16'h94, 1, 1'b1, "R12 slot kept");
    // R10
    chkBlk(16'hA0, 1'b0, "R10 not blocked before");
    acc(K_LR, 16'hA0, 1, 1'b1, "R2 locked read success");
    chkBlk(16'hA0, 1'b1, "R10 blocked after locked read");
    chkBlk(16'hA1, 1'b0, "R10 other line free");
    acc(K_LW, 16'hA0, 1, 1'b1, "R2 locked write success");
    chkBlk(16'hA0, 1'b0, "R10 unblocked after locked write");
    acc(K_LL, 16'hB0, 2, 1'b1, "R2 LL");
    acc(K_LR, 16'hB0, 2, 1'b1, "R2 locked read");
    acc(K_LW, 16'hB0, 2, 1'b1, "R2 locked write");
    acc(K_SC, 16'hB0, 2, 1'b0, "R6 locked RMW cleared own lock");
    idle(1'b0, 0, 1'b0);
    repeat (3) idle(1'b0, 0, 1'b0);
    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL R2 missing responses: actual %0d expected 0", expQ.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule